// File: doc/BRIEF.md
# I2C SCL Clock Divider

This block produces the serial clock phases of an I2C controller from a fast input clock. Software sets three configuration values over a small write port: a prescaler, a low-phase count and a high-phase count. The prescaler turns the input clock into a slower tick. A phase counter then times the low phase and the high phase in ticks. Each phase is stretched by a fixed offset `d`, which the hardware picks from the prescaler value. A mode input can force the offset to 6 instead.

The output `scl_pull_low` is an open-drain style enable. It is asserted while the clock line must be pulled low. Two one-cycle strobes mark the phase boundaries. `sample_stb` marks the start of each high phase, where data is sampled. `change_stb` marks the start of each low phase, where data may change. A module hold input (`ctl_hold`) parks the divider.

The state machine has four states:
- PH_HOLD is the reset and hold state. The line is released.
- PH_LOW drives the line low.
- PH_HIGH releases the line.
- PH_STOP is a parked state, entered when the high count is zero.

The transitions are:
- hold-release: PH_HOLD to PH_LOW, or to PH_STOP when the high register is 0.
- low-done: PH_LOW to PH_HIGH, on the final tick of the low phase.
- high-done: PH_HIGH to PH_LOW, on the final tick of the high phase.
- hold-entry: any state to PH_HOLD while `ctl_hold` is 1.

Top module: `scl_clk_divider`

## Requirements
- R1: The module tick occurs once every prescaler+1 input clock cycles, so every phase lasts a whole multiple of prescaler+1 cycles.
- R2: The low phase lasts (low + d) × (prescaler + 1) cycles, and `scl_pull_low` is 1 for the whole of it.
- R3: The high phase lasts (high + d) × (prescaler + 1) cycles, and `scl_pull_low` is 0 for the whole of it.
- R4: With `offset6_sel` = 0, the offset d is 7 when the prescaler is 0, 6 when it is 1, and 5 when it is 2 or more.
- R5: With `offset6_sel` = 1, the offset d is 6 for any prescaler value.
- R6: If the high register holds 0 when hold is released, no clock is generated: the line stays released and neither strobe pulses.
- R7: Holding behaviour:
  - While `ctl_hold` is 1, the line is released and both strobes are 0, starting from the cycle after `ctl_hold` is sampled high.
  - After release, the low phase comes first, beginning in the cycle after the edge that samples `ctl_hold` low.
- R8: `change_stb` is 1 for exactly the first cycle of each low phase, and `sample_stb` is 1 for exactly the first cycle of each high phase. The two strobes are never 1 together.
- R9: The prescaler, low, high and `offset6_sel` values are captured only while the divider is in hold. Writes and mode changes made while running have no effect until the next hold release.
- R10: The write address map is 0 = prescaler, 1 = low count, 2 = high count. A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_hold | input | 1 | Module hold: parks the divider and loads new settings |
| offset6_sel | input | 1 | Forces the phase offset to 6 |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register select (0 prescaler, 1 low, 2 high) |
| cfg_wdata | input | DATA_W (8) | Write data |
| scl_pull_low | output | 1 | Drive-low enable for the SCL line |
| sample_stb | output | 1 | One-cycle strobe at the start of a high phase |
| change_stb | output | 1 | One-cycle strobe at the start of a low phase |

## Verification
The bench builds the block with its default parameters: an 8-bit prescaler and 8-bit phase registers, giving 9-bit phase-length counters. It keeps the prescaler between 0 and 5 and the phase values small. This makes every branch of the offset rule reachable, along with the forced offset, within periods of a few tens of cycles, so each setting can be measured over more than one phase boundary. The stopped clock, mid-run writes, a hold asserted during a low phase, and the unused address are all covered with the same settings.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

    typedef enum logic [1:0] {
        PH_HOLD = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2,
        PH_STOP = 2'd3
    } phase_e;

    localparam logic [1:0] ADDR_PSC  = 2'd0;
    localparam logic [1:0] ADDR_LOW  = 2'd1;
    localparam logic [1:0] ADDR_HIGH = 2'd2;

    // Phase stretch in ticks: larger when the prescaler is small.
    function automatic logic [2:0] phase_offset(input logic psc_zero,
                                                input logic psc_one,
                                                input logic force6);
        logic [2:0] d;
        if (force6)        d = 3'd6;
        else if (psc_zero) d = 3'd7;
        else if (psc_one)  d = 3'd6;
        else               d = 3'd5;
        return d;
    endfunction

endpackage

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs
    import scl_div_pkg::*;
#(
    parameter int PSC_W  = 8,
    parameter int PH_W   = 8,
    parameter int DATA_W = 8,
    localparam int LEN_W = PH_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              force6,
    input  logic              capture,
    output logic [PSC_W-1:0]  psc_act,
    output logic [LEN_W-1:0]  low_len,
    output logic [LEN_W-1:0]  high_len,
    output logic              high_zero_live
);

    logic [PSC_W-1:0] psc_reg;
    logic [PH_W-1:0]  low_reg, high_reg;
    logic [PH_W-1:0]  low_act, high_act;
    logic             force_act;
    logic [2:0]       d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_reg  <= '0;
            low_reg  <= '0;
            high_reg <= '0;
        end else if (we) begin
            unique case (addr)
                ADDR_PSC:  psc_reg  <= wdata[PSC_W-1:0];
                ADDR_LOW:  low_reg  <= wdata[PH_W-1:0];
                ADDR_HIGH: high_reg <= wdata[PH_W-1:0];
                default:   ;
            endcase
        end
    end

    // Working copies are refreshed only while the divider is parked.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_act   <= '0;
            low_act   <= '0;
            high_act  <= '0;
            force_act <= 1'b0;
        end else if (capture) begin
            psc_act   <= psc_reg;
            low_act   <= low_reg;
            high_act  <= high_reg;
            force_act <= force6;
        end
    end

    always_comb begin
        d        = phase_offset(psc_act == '0, psc_act == PSC_W'(1), force_act);
        low_len  = {1'b0, low_act}  + LEN_W'(d);
        high_len = {1'b0, high_act} + LEN_W'(d);
    end

    assign high_zero_live = (high_reg == '0);

endmodule

// File: rtl/scl_tick_gen.sv
module scl_tick_gen #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);

    logic [PSC_W-1:0] pcnt;

    assign tick = run && (pcnt == psc);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pcnt <= '0;
        else if (!run)   pcnt <= '0;
        else if (tick)   pcnt <= '0;
        else             pcnt <= pcnt + PSC_W'(1);
    end

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_div_pkg::*;
#(
    parameter int LEN_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             tick,
    input  logic             high_zero_live,
    input  logic [LEN_W-1:0] low_len,
    input  logic [LEN_W-1:0] high_len,
    output logic             in_hold,
    output logic             running,
    output logic             pull_low,
    output logic             rise_stb,
    output logic             fall_stb
);

    phase_e           state_q, state_d;
    logic [LEN_W-1:0] cnt;
    logic             low_done, high_done;

    assign low_done  = tick && (cnt == low_len  - LEN_W'(1));
    assign high_done = tick && (cnt == high_len - LEN_W'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_HOLD: if (!hold) state_d = high_zero_live ? PH_STOP : PH_LOW;
            PH_LOW:  if (hold) state_d = PH_HOLD;
                     else if (low_done) state_d = PH_HIGH;
            PH_HIGH: if (hold) state_d = PH_HOLD;
                     else if (high_done) state_d = PH_LOW;
            PH_STOP: if (hold) state_d = PH_HOLD;
        endcase
    end

    // State register and phase tick counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_HOLD;
            cnt     <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) cnt <= '0;
            else if (tick)          cnt <= cnt + LEN_W'(1);
        end
    end

    // Registered outputs, aligned with the state they describe.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pull_low <= 1'b0;
            rise_stb <= 1'b0;
            fall_stb <= 1'b0;
        end else begin
            pull_low <= (state_d == PH_LOW);
            rise_stb <= (state_d == PH_HIGH) && (state_q != PH_HIGH);
            fall_stb <= (state_d == PH_LOW)  && (state_q != PH_LOW);
        end
    end

    assign in_hold = (state_q == PH_HOLD);
    assign running = (state_q == PH_LOW) || (state_q == PH_HIGH);

endmodule

// File: rtl/scl_clk_divider.sv
module scl_clk_divider
    import scl_div_pkg::*;
#(
    parameter int PSC_W = 8,
    parameter int PH_W  = 8,
    localparam int DATA_W = (PSC_W > PH_W) ? PSC_W : PH_W,
    localparam int LEN_W  = PH_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_hold,
    input  logic              offset6_sel,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              scl_pull_low,
    output logic              sample_stb,
    output logic              change_stb
);

    logic [PSC_W-1:0] psc_act;
    logic [LEN_W-1:0] low_len, high_len;
    logic             high_zero_live, in_hold, running, tick;

    scl_cfg_regs #(.PSC_W(PSC_W), .PH_W(PH_W), .DATA_W(DATA_W)) i_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .we             (cfg_we),
        .addr           (cfg_addr),
        .wdata          (cfg_wdata),
        .force6         (offset6_sel),
        .capture        (in_hold),
        .psc_act        (psc_act),
        .low_len        (low_len),
        .high_len       (high_len),
        .high_zero_live (high_zero_live)
    );

    scl_tick_gen #(.PSC_W(PSC_W)) i_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (running),
        .psc   (psc_act),
        .tick  (tick)
    );

    scl_phase_fsm #(.LEN_W(LEN_W)) i_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .hold           (ctl_hold),
        .tick           (tick),
        .high_zero_live (high_zero_live),
        .low_len        (low_len),
        .high_len       (high_len),
        .in_hold        (in_hold),
        .running        (running),
        .pull_low       (scl_pull_low),
        .rise_stb       (sample_stb),
        .fall_stb       (change_stb)
    );

endmodule

// File: rtl/scl_clk_divider_chk.sv
module scl_clk_divider_chk (
    input logic clk,
    input logic rst_n,
    input logic hold,
    input logic pull_low,
    input logic rise,
    input logic fall
);

    assert_hold_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (!pull_low && !rise && !fall));

    assert_fall_marks_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pull_low) |-> fall);

    assert_fall_only_on_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fall |-> $rose(pull_low));

    assert_rise_after_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> $fell(pull_low));

    assert_strobes_apart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise && fall));

    // Smallest low phase is 5 ticks, so a fresh low lasts past one cycle.
    assert_low_not_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pull_low) && !hold) |=> pull_low);

endmodule

bind scl_clk_divider scl_clk_divider_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (ctl_hold),
    .pull_low (scl_pull_low),
    .rise     (sample_stb),
    .fall     (change_stb)
);

// File: tb/test_scl_clk_divider.sv
module test_scl_clk_divider;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_hold = 1'b1;
    logic       offset6_sel = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = 2'd0;
    logic [7:0] cfg_wdata = 8'd0;
    logic       scl_pull_low, sample_stb, change_stb;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    scl_clk_divider i_scl_clk_divider (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_hold     (ctl_hold),
        .offset6_sel  (offset6_sel),
        .cfg_we       (cfg_we),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .scl_pull_low (scl_pull_low),
        .sample_stb   (sample_stb),
        .change_stb   (change_stb)
    );

    // psc, low, high, force6, expected low cycles, expected high cycles, 1 = forced offset
    localparam int NV = 6;
    localparam int VEC [NV][7] = '{
        '{0, 3, 2, 0, 10,  9, 0},
        '{1, 2, 4, 0, 16, 20, 0},
        '{2, 1, 1, 0, 18, 18, 0},
        '{0, 3, 2, 1,  9,  8, 1},
        '{3, 4, 2, 1, 40, 32, 1},
        '{5, 0, 1, 0, 30, 36, 0}
    };

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: act %0d cycles exp below 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act %0d exp %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Park, program, release; returns at the first cycle after release.
    task automatic start_run(input int psc, input int lo, input int hi, input int f6);
        @(negedge clk);
        ctl_hold = 1'b1;
        @(negedge clk);
        wr(2'd0, 8'(psc));
        wr(2'd1, 8'(lo));
        wr(2'd2, 8'(hi));
        offset6_sel = f6[0];
        ctl_hold = 1'b0;
        @(negedge clk);
    endtask

    // Called in the first cycle of a phase; returns in the first cycle of the next.
    task automatic measure(input logic want, output int n);
        n = 1;
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            if (scl_pull_low != want) break;
            n++;
        end
    endtask

    initial begin
        int nl, nh;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7: reset / hold state
        chk(scl_pull_low == 0, "R7 line released in hold", int'(scl_pull_low), 0);
        chk(sample_stb == 0 && change_stb == 0, "R7 strobes quiet in hold",
            int'(sample_stb) + int'(change_stb), 0);

        // Table of settings (R1 R2 R3 R4 R5 R8)
        for (int v = 0; v < NV; v++) begin
            start_run(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
            chk(scl_pull_low == 1 && change_stb == 1, "R7 low phase first with change strobe",
                int'(scl_pull_low) + int'(change_stb), 2);
            measure(1'b1, nl);
            chk(nl == VEC[v][4], VEC[v][6] ? "R2 low length (R5)" : "R2 low length (R4)", nl, VEC[v][4]);
            chk(sample_stb == 1, "R8 sample strobe at high start", int'(sample_stb), 1);
            measure(1'b0, nh);
            chk(nh == VEC[v][5], VEC[v][6] ? "R3 high length (R5)" : "R3 high length (R4)", nh, VEC[v][5]);
            chk(change_stb == 1, "R8 change strobe at low start", int'(change_stb), 1);
            chk((nl % (VEC[v][0] + 1)) == 0, "R1 phase is whole ticks", nl % (VEC[v][0] + 1), 0);
            measure(1'b1, nl);
            chk(nl == VEC[v][4], "R2 second low length", nl, VEC[v][4]);
        end

        // R6: high count of zero stops the clock
        begin
            int seen;
            seen = 0;
            start_run(0, 3, 0, 0);
            for (int k = 0; k < 60; k++) begin
                if (scl_pull_low || sample_stb || change_stb) seen++;
                @(negedge clk);
            end
            chk(seen == 0, "R6 no clock with high 0", seen, 0);
        end

        // R9: writes and mode change while running take effect only after hold
        start_run(0, 3, 2, 0);
        measure(1'b1, nl);
        wr(2'd1, 8'd9);
        offset6_sel = 1'b1;
        measure(1'b0, nh);
        chk(nh == 8, "R9 high unaffected mid-run", nh, 8); // 9 minus one cycle spent above
        measure(1'b1, nl);
        chk(nl == 10, "R9 low unaffected mid-run", nl, 10);
        start_run(0, 9, 2, 0);
        measure(1'b1, nl);
        chk(nl == 16, "R9 new low after hold", nl, 16);

        // R10: address 3 is ignored
        @(negedge clk);
        ctl_hold = 1'b1;
        @(negedge clk);
        wr(2'd0, 8'd0); wr(2'd1, 8'd3); wr(2'd2, 8'd2);
        wr(2'd3, 8'h55);
        offset6_sel = 1'b0;
        ctl_hold = 1'b0;
        @(negedge clk);
        measure(1'b1, nl);
        chk(nl == 10, "R10 address 3 leaves low", nl, 10);
        measure(1'b0, nh);
        chk(nh == 9, "R10 address 3 leaves high", nh, 9);

        // R7: hold asserted in the middle of a low phase
        @(negedge clk);
        @(negedge clk);
        ctl_hold = 1'b1;
        @(negedge clk);
        chk(scl_pull_low == 0, "R7 line released after hold", int'(scl_pull_low), 0);
        chk(sample_stb == 0 && change_stb == 0, "R7 strobes quiet after hold",
            int'(sample_stb) + int'(change_stb), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule